// File: doc/BRIEF.md
# Banked CPU Register File

This block is the architectural register store of a small 16-bit processor core. It keeps two copies of a group of seven 16-bit registers: four general data registers (D0 to D3), two address registers (AD0, AD1) and a frame pointer (FRM). Beside them sit registers that both copies share: a user and an interrupt stack pointer, a static base, a 20-bit interrupt vector table base, a 20-bit program counter and a 16-bit flag word. One bit of the flag word picks the live copy of the banked group. A second bit picks which stack pointer the stack selector reaches.

The core reads through one combinational read port and writes through one synchronous write port. Each port names a register with a 4-bit selector and an access size with a 2-bit code: 0 is the low byte, 1 is the high byte, 2 is the 16-bit word and 3 is the 32-bit pair. The size codes let the same storage appear as bytes, words or register pairs. The flag word is also driven straight out for the decode and interrupt logic around the block.

Selector codes: 0 D0, 1 D1, 2 D2, 3 D3, 4 AD0, 5 AD1, 6 FRM, 7 SP (routed by the stack-select flag), 8 SB, 9 TBL_LO, 10 TBL_HI, 11 PC, 12 FLG. Codes 13 to 15 are unused.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every register reads zero at every selector and size, and `flags` is zero.
- R2: Selectors 0 to 6 reach the bank picked by flag bit 4 (B). A write changes only that bank. The other bank keeps its values and shows them again once B selects it.
- R3: Only D0 and D1 accept byte sizes. Size 0 reaches bits 7:0 and size 1 reaches bits 15:8. A byte write takes its data from `wr_data[7:0]` and leaves the other byte unchanged. A byte read returns the byte zero-extended.
- R4: Size 3 on D0, D1 and AD0 forms the pairs D2:D0, D3:D1 and AD1:AD0. The partner register (D2, D3, AD1) holds bits 31:16. A pair write updates both halves on the same clock edge.
- R5: Selector 7 reaches the user stack pointer when flag bit 7 (U) is 0 and the interrupt stack pointer when U is 1. The other stack pointer is left unchanged.
- R6: The table base is 20 bits wide. A word on TBL_LO reaches bits 15:0, and a word on TBL_HI reaches bits 19:16 through data bits 3:0. A pair on TBL_LO reads or writes all 20 bits. A partial write keeps the bits it does not cover.
- R7: The flag word holds C, D, Z, S, B, O, I and U in bits 0 to 7, and a 3-bit interrupt priority level in bits 14:12. Bits 11:8 and 15 read zero. `flags` always equals the stored flag word.
- R8: A selector and size pair outside the legal set writes nothing and reads zero. The legal set is: D0/D1 with any size; D2, D3, AD1, FRM, SP, SB, TBL_HI and FLG with word only; AD0 and TBL_LO with word or pair; PC with pair only.
- R9: The program counter is reached only as a pair and holds data bits 19:0. SB is a plain 16-bit word.
- R10: Writes use the B and U values that were stored before the current edge. A flag write steers accesses from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Register selector of the write |
| wr_size | input | 2 | Access size of the write |
| wr_data | input | 32 | Write data, right-aligned |
| rd_sel | input | 4 | Register selector of the read |
| rd_size | input | 2 | Access size of the read |
| rd_data | output | 32 | Read data, zero-extended |
| flags | output | 16 | Current flag word |

## Verification
The assertions check on every cycle that the bank not selected by B stays frozen, that a pair write fills both halves, that illegal writes leave all storage untouched, that the stack write avoids the other pointer and that a flag write lands with its reserved bits cleared. The bench's sweeps show the aliasing itself. A byte, word or pair written through one view must read back correctly through every other view in both banks, including merged bytes, the split table base and the one-cycle lag between a flag write and the bank it selects.

// File: rtl/brf_pkg.sv
`timescale 1ns/1ps
package brf_pkg;
  localparam int WORD_W   = 16;
  localparam int WIDE_W   = 20;
  localparam int TBL_HI_W = WIDE_W - WORD_W;
  localparam int NBANK    = 2;
  localparam int NBREG    = 7;
  localparam int BIDX_W   = $clog2(NBREG);
  localparam int BSEL_W   = $clog2(NBANK);
  localparam int PORT_W   = 2 * WORD_W;

  // flag word: status bits 0..7 (carry .. stack select), priority field above
  localparam int FB_C    = 0;
  localparam int FB_B    = 4;
  localparam int FB_U    = 7;
  localparam int IPL_LSB = 12;
  localparam int IPL_W   = 3;

  typedef enum logic [3:0] {
    SEL_D0 = 4'd0, SEL_D1 = 4'd1, SEL_D2 = 4'd2, SEL_D3 = 4'd3,
    SEL_AD0 = 4'd4, SEL_AD1 = 4'd5, SEL_FRM = 4'd6, SEL_SP = 4'd7,
    SEL_SB = 4'd8, SEL_TBL_LO = 4'd9, SEL_TBL_HI = 4'd10, SEL_PC = 4'd11,
    SEL_FLG = 4'd12
  } sel_e;

  typedef enum logic [1:0] {
    SZ_LO8 = 2'd0, SZ_HI8 = 2'd1, SZ_W16 = 2'd2, SZ_P32 = 2'd3
  } size_e;

  function automatic logic [WORD_W-1:0] flg_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = FB_C; i <= FB_U; i++) m[i] = 1'b1;
    for (int i = 0; i < IPL_W; i++) m[IPL_LSB + i] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] FLG_MASK = flg_mask();

  function automatic logic is_banked(sel_e s);
    return s <= SEL_FRM;
  endfunction

  // legal selector/size combinations
  function automatic logic access_ok(sel_e s, size_e z);
    case (s)
      SEL_D0, SEL_D1:          return 1'b1;
      SEL_AD0, SEL_TBL_LO:     return (z == SZ_W16) || (z == SZ_P32);
      SEL_PC:                  return z == SZ_P32;
      SEL_D2, SEL_D3, SEL_AD1, SEL_FRM, SEL_SP, SEL_SB, SEL_TBL_HI, SEL_FLG:
                               return z == SZ_W16;
      default:                 return 1'b0;
    endcase
  endfunction

  // index of the register holding the upper half of a pair
  function automatic int pair_hi(sel_e s);
    case (s)
      SEL_D0:  return int'(SEL_D2);
      SEL_D1:  return int'(SEL_D3);
      SEL_AD0: return int'(SEL_AD1);
      default: return 0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] put_byte(logic [WORD_W-1:0] old,
                                                 logic [7:0] b, logic hi);
    logic [WORD_W-1:0] r;
    r = old;
    if (hi) r[15:8] = b;
    else    r[7:0]  = b;
    return r;
  endfunction
endpackage

// File: rtl/brf_bank.sv
`timescale 1ns/1ps
module brf_bank #(
  parameter int NREG = 7,
  parameter int W    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          we,
  input  logic [NREG-1:0][W-1:0]   wdata,
  output logic [NREG-1:0][W-1:0]   q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (we[i]) q[i] <= wdata[i];
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    // R2: a register with no enable keeps its value
    assert_reg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !we[i] |=> $stable(q[i]));
  end
endmodule

// File: rtl/brf_ctrl.sv
`timescale 1ns/1ps
module brf_ctrl
  import brf_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int WW = WIDE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_usp,
  input  logic          we_isp,
  input  logic          we_sb,
  input  logic          we_tbl,
  input  logic          we_pc,
  input  logic          we_flg,
  input  logic [W-1:0]  sp_d,
  input  logic [W-1:0]  sb_d,
  input  logic [W-1:0]  flg_d,
  input  logic [WW-1:0] tbl_d,
  input  logic [WW-1:0] pc_d,
  output logic [W-1:0]  usp_q,
  output logic [W-1:0]  isp_q,
  output logic [W-1:0]  sb_q,
  output logic [WW-1:0] tbl_q,
  output logic [WW-1:0] pc_q,
  output logic [W-1:0]  flg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usp_q <= '0;
      isp_q <= '0;
      sb_q  <= '0;
      tbl_q <= '0;
      pc_q  <= '0;
      flg_q <= '0;
    end else begin
      if (we_usp) usp_q <= sp_d;
      if (we_isp) isp_q <= sp_d;
      if (we_sb)  sb_q  <= sb_d;
      if (we_tbl) tbl_q <= tbl_d;
      if (we_pc)  pc_q  <= pc_d;
      if (we_flg) flg_q <= flg_d & W'(FLG_MASK);
    end
  end

  // R5: the decoder never strobes both stack pointers
  assert_one_stack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_usp, we_isp}));

  // R9: program counter only moves when strobed
  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_pc |=> $stable(pc_q));
endmodule

// File: rtl/brf_wr_decode.sv
`timescale 1ns/1ps
module brf_wr_decode
  import brf_pkg::*;
(
  input  logic                          wr_en,
  input  sel_e                          sel,
  input  size_e                         size,
  input  logic [PORT_W-1:0]             wdata,
  input  logic                          stk_sel,
  input  logic [NBREG-1:0][WORD_W-1:0]  bank_q,
  input  logic [WIDE_W-1:0]             tbl_q,
  output logic                          legal,
  output logic [NBREG-1:0]              bank_we,
  output logic [NBREG-1:0][WORD_W-1:0]  bank_wd,
  output logic                          we_usp,
  output logic                          we_isp,
  output logic                          we_sb,
  output logic                          we_tbl,
  output logic                          we_pc,
  output logic                          we_flg,
  output logic [WORD_W-1:0]             word_d,
  output logic [WIDE_W-1:0]             tbl_d,
  output logic [WIDE_W-1:0]             pc_d
);
  logic                go;
  logic [BIDX_W-1:0]   k_lo;
  logic [BIDX_W-1:0]   k_hi;

  assign legal  = access_ok(sel, size);
  assign go     = wr_en && legal;
  assign k_lo   = BIDX_W'(sel);
  assign k_hi   = BIDX_W'(pair_hi(sel));
  assign word_d = wdata[WORD_W-1:0];
  assign pc_d   = wdata[WIDE_W-1:0];

  always_comb begin
    bank_we = '0;
    bank_wd = bank_q;
    we_usp  = 1'b0;
    we_isp  = 1'b0;
    we_sb   = 1'b0;
    we_tbl  = 1'b0;
    we_pc   = 1'b0;
    we_flg  = 1'b0;
    tbl_d   = tbl_q;
    if (go) begin
      if (is_banked(sel)) begin
        bank_we[k_lo] = 1'b1;
        case (size)
          SZ_LO8:  bank_wd[k_lo] = put_byte(bank_q[k_lo], wdata[7:0], 1'b0);
          SZ_HI8:  bank_wd[k_lo] = put_byte(bank_q[k_lo], wdata[7:0], 1'b1);
          SZ_W16:  bank_wd[k_lo] = wdata[WORD_W-1:0];
          default: begin
            bank_wd[k_lo] = wdata[WORD_W-1:0];
            bank_wd[k_hi] = wdata[PORT_W-1:WORD_W];
            bank_we[k_hi] = 1'b1;
          end
        endcase
      end else begin
        case (sel)
          SEL_SP: begin
            we_isp = stk_sel;
            we_usp = !stk_sel;
          end
          SEL_SB:  we_sb = 1'b1;
          SEL_TBL_LO: begin
            we_tbl = 1'b1;
            if (size == SZ_P32) tbl_d = wdata[WIDE_W-1:0];
            else                tbl_d[WORD_W-1:0] = wdata[WORD_W-1:0];
          end
          SEL_TBL_HI: begin
            we_tbl = 1'b1;
            tbl_d[WIDE_W-1:WORD_W] = wdata[TBL_HI_W-1:0];
          end
          SEL_PC:  we_pc  = 1'b1;
          SEL_FLG: we_flg = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/brf_rd_mux.sv
`timescale 1ns/1ps
module brf_rd_mux
  import brf_pkg::*;
(
  input  sel_e                          sel,
  input  size_e                         size,
  input  logic                          stk_sel,
  input  logic [NBREG-1:0][WORD_W-1:0]  bank_q,
  input  logic [WORD_W-1:0]             usp_q,
  input  logic [WORD_W-1:0]             isp_q,
  input  logic [WORD_W-1:0]             sb_q,
  input  logic [WIDE_W-1:0]             tbl_q,
  input  logic [WIDE_W-1:0]             pc_q,
  input  logic [WORD_W-1:0]             flg_q,
  output logic                          legal,
  output logic [PORT_W-1:0]             rdata
);
  logic [BIDX_W-1:0] k_lo;
  logic [BIDX_W-1:0] k_hi;

  assign legal = access_ok(sel, size);
  assign k_lo  = BIDX_W'(sel);
  assign k_hi  = BIDX_W'(pair_hi(sel));

  always_comb begin
    rdata = '0;
    if (legal) begin
      if (is_banked(sel)) begin
        case (size)
          SZ_LO8:  rdata = PORT_W'(bank_q[k_lo][7:0]);
          SZ_HI8:  rdata = PORT_W'(bank_q[k_lo][15:8]);
          SZ_W16:  rdata = PORT_W'(bank_q[k_lo]);
          default: rdata = {bank_q[k_hi], bank_q[k_lo]};
        endcase
      end else begin
        case (sel)
          SEL_SP:     rdata = PORT_W'(stk_sel ? isp_q : usp_q);
          SEL_SB:     rdata = PORT_W'(sb_q);
          SEL_TBL_LO: rdata = (size == SZ_P32) ? PORT_W'(tbl_q)
                                               : PORT_W'(tbl_q[WORD_W-1:0]);
          SEL_TBL_HI: rdata = PORT_W'(tbl_q[WIDE_W-1:WORD_W]);
          SEL_PC:     rdata = PORT_W'(pc_q);
          SEL_FLG:    rdata = PORT_W'(flg_q);
          default:    rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
  import brf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [1:0]  wr_size,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_sel,
  input  logic [1:0]  rd_size,
  output logic [31:0] rd_data,
  output logic [15:0] flags
);
  logic [NBREG-1:0][WORD_W-1:0] bank_q [NBANK];
  logic [NBREG-1:0][WORD_W-1:0] act_q;
  logic [NBREG-1:0]             dec_we;
  logic [NBREG-1:0][WORD_W-1:0] dec_wd;
  logic [BSEL_W-1:0]            bsel;
  logic                         ssel;
  logic                         wr_legal;
  logic                         rd_legal;
  logic we_usp, we_isp, we_sb, we_tbl, we_pc, we_flg;
  logic [WORD_W-1:0] word_d, usp_q, isp_q, sb_q, flg_q;
  logic [WIDE_W-1:0] tbl_d, pc_d, tbl_q, pc_q;

  assign bsel  = flg_q[FB_B +: BSEL_W];
  assign ssel  = flg_q[FB_U];
  assign act_q = bank_q[bsel];
  assign flags = flg_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NBREG-1:0] we_b;
    assign we_b = (bsel == BSEL_W'(b)) ? dec_we : '0;

    brf_bank #(.NREG(NBREG), .W(WORD_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_b),
      .wdata (dec_wd),
      .q     (bank_q[b])
    );

    // R2: the bank not selected is never touched
    assert_idle_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bsel != BSEL_W'(b)) |=> $stable(bank_q[b]));

    // R4: pair write on D1 fills D3 (upper) and D1 (lower) together
    assert_pair_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_D1 && wr_size == SZ_P32 && bsel == BSEL_W'(b))
      |=> (bank_q[b][3] == $past(wr_data[31:16]) && bank_q[b][1] == $past(wr_data[15:0])));

    // R8: illegal combinations leave the banks alone
    assert_illegal_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_legal) |=> $stable(bank_q[b]));
  end

  brf_wr_decode u_dec (
    .wr_en   (wr_en),
    .sel     (sel_e'(wr_sel)),
    .size    (size_e'(wr_size)),
    .wdata   (wr_data),
    .stk_sel (ssel),
    .bank_q  (act_q),
    .tbl_q   (tbl_q),
    .legal   (wr_legal),
    .bank_we (dec_we),
    .bank_wd (dec_wd),
    .we_usp  (we_usp),
    .we_isp  (we_isp),
    .we_sb   (we_sb),
    .we_tbl  (we_tbl),
    .we_pc   (we_pc),
    .we_flg  (we_flg),
    .word_d  (word_d),
    .tbl_d   (tbl_d),
    .pc_d    (pc_d)
  );

  brf_ctrl #(.W(WORD_W), .WW(WIDE_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_usp (we_usp),
    .we_isp (we_isp),
    .we_sb  (we_sb),
    .we_tbl (we_tbl),
    .we_pc  (we_pc),
    .we_flg (we_flg),
    .sp_d   (word_d),
    .sb_d   (word_d),
    .flg_d  (word_d),
    .tbl_d  (tbl_d),
    .pc_d   (pc_d),
    .usp_q  (usp_q),
    .isp_q  (isp_q),
    .sb_q   (sb_q),
    .tbl_q  (tbl_q),
    .pc_q   (pc_q),
    .flg_q  (flg_q)
  );

  brf_rd_mux u_rd (
    .sel     (sel_e'(rd_sel)),
    .size    (size_e'(rd_size)),
    .stk_sel (ssel),
    .bank_q  (act_q),
    .usp_q   (usp_q),
    .isp_q   (isp_q),
    .sb_q    (sb_q),
    .tbl_q   (tbl_q),
    .pc_q    (pc_q),
    .flg_q   (flg_q),
    .legal   (rd_legal),
    .rdata   (rd_data)
  );

  // R8: an illegal read returns zero
  always_comb begin
    if (rst_n && !rd_legal)
      assert_illegal_read_R8: assert (rd_data == '0);
  end

  // R7: a flag write lands with the reserved bits cleared
  assert_flag_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_FLG && wr_size == SZ_W16)
    |=> flags == ($past(wr_data[15:0]) & 16'h70FF));

  // R5: stack access with U clear reaches the user pointer only
  assert_user_stack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SP && wr_size == SZ_W16 && !ssel)
    |=> ($stable(isp_q) && usp_q == $past(wr_data[15:0])));

  // R6: writing the upper table nibble keeps the lower 16 bits
  assert_tbl_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_TBL_HI && wr_size == SZ_W16)
    |=> ($stable(tbl_q[15:0]) && tbl_q[19:16] == $past(wr_data[3:0])));

  // R8: illegal writes leave the flag word alone
  assert_illegal_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_legal) |=> $stable(flg_q));
endmodule

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_sel = '0;
  logic [1:0]  rd_size = '0;
  logic [31:0] rd_data;
  logic [15:0] flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state kept by the bench
  logic [15:0] mb [2][7];
  logic [15:0] usp, isp, sb, fl;
  logic [19:0] tb, pc;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_size(wr_size), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_size(rd_size), .rd_data(rd_data), .flags(flags)
  );

  always #2.5 clk = ~clk;

  function automatic bit ok(int s, int z);
    if (s == 0 || s == 1) return 1'b1;
    if (s == 4 || s == 9) return z >= 2;
    if (s == 11) return z == 3;
    if (s == 2 || s == 3 || s == 5 || s == 6 || s == 7 || s == 8 || s == 10 || s == 12)
      return z == 2;
    return 1'b0;
  endfunction

  function automatic int hi_of(int s);
    return (s == 4) ? 5 : s + 2;
  endfunction

  function automatic string tag_of(int s, int z);
    if (!ok(s, z)) return "R8";
    if (s <= 1 && z < 2) return "R3";
    if (z == 3 && (s <= 1 || s == 4)) return "R4";
    if (s <= 6) return "R2";
    if (s == 7) return "R5";
    if (s == 9 || s == 10) return "R6";
    if (s == 8 || s == 11) return "R9";
    return "R7";
  endfunction

  task automatic model_write(int s, int z, logic [31:0] d);
    int b;
    if (!ok(s, z)) return;
    b = int'(fl[4]);
    if (s <= 6) begin
      if (z == 0)      mb[b][s][7:0]  = d[7:0];
      else if (z == 1) mb[b][s][15:8] = d[7:0];
      else begin
        mb[b][s] = d[15:0];
        if (z == 3) mb[b][hi_of(s)] = d[31:16];
      end
    end else begin
      case (s)
        7:  if (fl[7]) isp = d[15:0]; else usp = d[15:0];
        8:  sb = d[15:0];
        9:  if (z == 3) tb = d[19:0]; else tb[15:0] = d[15:0];
        10: tb[19:16] = d[3:0];
        11: pc = d[19:0];
        default: fl = d[15:0] & 16'h70FF;
      endcase
    end
  endtask

  function automatic logic [31:0] model_read(int s, int z);
    int b;
    b = int'(fl[4]);
    if (!ok(s, z)) return 32'h0;
    if (s <= 6) begin
      case (z)
        0: return {24'h0, mb[b][s][7:0]};
        1: return {24'h0, mb[b][s][15:8]};
        2: return {16'h0, mb[b][s]};
        default: return {mb[b][hi_of(s)], mb[b][s]};
      endcase
    end
    case (s)
      7:  return {16'h0, (fl[7] ? isp : usp)};
      8:  return {16'h0, sb};
      9:  return (z == 3) ? {12'h0, tb} : {16'h0, tb[15:0]};
      10: return {28'h0, tb[19:16]};
      11: return {12'h0, pc};
      default: return {16'h0, fl};
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_write(int s, int z, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(s); wr_size = 2'(z); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(s, z, d);
  endtask

  task automatic read_chk(int s, int z, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_sel = 4'(s); rd_size = 2'(z);
    #1;
    check(rd_data, exp, tag, $sformatf("read sel=%0d size=%0d", s, z));
  endtask

  task automatic read_all();
    for (int s = 0; s < 16; s++)
      for (int z = 0; z < 4; z++)
        read_chk(s, z, model_read(s, z), tag_of(s, z));
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 7; k++) mb[b][k] = '0;
    usp = '0; isp = '0; sb = '0; fl = '0; tb = '0; pc = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything clear after reset
    check({16'h0, flags}, 32'h0, "R1", "flags after reset");
    for (int s = 0; s < 16; s++)
      for (int z = 0; z < 4; z++)
        read_chk(s, z, 32'h0, "R1");

    // sweeps: pass 0 in bank 0 / user stack, pass 1 in bank 1 / interrupt stack
    for (int p = 0; p < 2; p++) begin
      do_write(12, 2, (p == 0) ? 32'h0 : 32'h0090);
      for (int s = 0; s < 16; s++) begin
        for (int z = 0; z < 4; z++) begin
          logic [31:0] d;
          d = 32'hA5C3_0F69 ^ (32'((p * 64 + s * 4 + z + 1)) * 32'h0100_0193);
          do_write(s, z, d);
          check({16'h0, flags}, {16'h0, fl}, "R7", "flags after sweep write");
          read_all();
        end
      end
    end

    // R10/R2: flag write steers the following access to the other bank
    do_write(12, 2, 32'h0000);
    do_write(0, 2, 32'h0000_1111);
    do_write(12, 2, 32'h0010);
    do_write(0, 2, 32'h0000_BEEF);
    read_chk(0, 2, 32'h0000_BEEF, "R10");
    do_write(12, 2, 32'h0000);
    read_chk(0, 2, 32'h0000_1111, "R2");

    // R3: high byte merge keeps the low byte
    do_write(1, 2, 32'h0000_1234);
    do_write(1, 1, 32'hFFFF_FFAB);
    read_chk(1, 2, 32'h0000_AB34, "R3");
    do_write(1, 0, 32'h0000_00CD);
    read_chk(1, 2, 32'h0000_ABCD, "R3");

    // R4: address pair, upper half in AD1
    do_write(4, 3, 32'hDEAD_5A5A);
    read_chk(5, 2, 32'h0000_DEAD, "R4");
    read_chk(4, 2, 32'h0000_5A5A, "R4");

    // R6: split table base
    do_write(9, 3, 32'hFFF1_2345);
    do_write(10, 2, 32'h0000_00F9);
    read_chk(9, 3, 32'h0009_2345, "R6");

    // R7: reserved flag bits read zero
    do_write(12, 2, 32'h0000_FFFF);
    check({16'h0, flags}, 32'h0000_70FF, "R7", "flags port after all-ones write");
    read_chk(12, 2, 32'h0000_70FF, "R7");

    // R5: U now set, stack access reaches interrupt pointer
    do_write(7, 2, 32'h0000_7777);
    do_write(12, 2, 32'h0000_0000);
    read_chk(7, 2, model_read(7, 2), "R5");
    do_write(12, 2, 32'h0000_0080);
    read_chk(7, 2, 32'h0000_7777, "R5");

    // R9: PC word access is illegal, pair holds 20 bits
    do_write(11, 3, 32'hFFFA_BCDE);
    do_write(11, 2, 32'h0000_0000);
    read_chk(11, 3, 32'h000A_BCDE, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule